// File: doc/BRIEF.md
# Stacked Floating-Point Register File

This block holds eight 80-bit operand registers and presents them to an arithmetic engine as a circular stack. A 3-bit pointer marks the current top. Every access names a stack-relative slot, and the slot is turned into a physical entry by adding it to the pointer modulo eight. Each entry carries a tag that says whether it holds a value or is empty. The block catches pushes onto an occupied entry (overflow) and accesses to an empty one (underflow). It reports both as an invalid operation, raises a stack-fault flag, and gives the direction of the fault in a condition-code bit.

The block also builds a 16-bit status word. The word holds six sticky exception flags, which the arithmetic side can also set through an input. It also holds the stack-fault bit, an error summary bit, four condition codes, the pointer and a busy bit. A 6-bit mask from the control word decides which of the set flags raise the interrupt request. Arithmetic is not part of this block. Operands are read through a combinational port, and results go back through the push and write commands.

A command port takes one operation per clock: none, push, pop, write-slot or initialise. A separate read strobe runs beside it and is checked for underflow in the same cycle. If any fault is found in a cycle, that cycle's command has no effect on the stack.

Top module: `fpstack_regfile`

## Requirements
- R1: After reset, or the cycle after an initialise command (cmd_op=4), status bits 0..14 are all zero, irq is low, and every entry is empty.
- R2: Slot i is read from physical entry (TOP+i) mod 8. After a push, the value that was at slot 0 is read at slot 1.
- R3: A push (cmd_op=1) whose target entry (TOP-1) mod 8 is empty decrements TOP modulo 8, stores wdata there and tags it valid.
- R4: A pop (cmd_op=2) of a valid top entry tags it empty and increments TOP modulo 8.
- R5: A push whose target is already valid is an overflow. It sets status bits 0 and 6 and sets C1 (bit 9) to 1. TOP and all entries stay unchanged.
- R6: A pop of an empty top entry, or a read strobe on an empty slot, is an underflow. It sets status bits 0 and 6 and sets C1 to 0. TOP does not move.
- R7: A write (cmd_op=3) to slot i replaces the data at (TOP+i) mod 8 and tags it valid. TOP does not change.
- R8: The exception flags (status bits 0..5) are sticky. Each ext_flags bit is ORed into them, and only reset or initialise clears them. Bit 7 is the OR of bits 0..5.
- R9: irq is high in the same cycle in which any set flag bit k has exc_mask bit k equal to 0.
- R10: cc_we loads cc_in {C3,C2,C1,C0} into status bits 14, 10, 9 and 8. If a stack fault occurs in the same cycle, C1 takes the fault direction instead of cc_in[1].
- R11: Status bit 15 follows busy_in in the same cycle.
- R12: Status bits 13..11 hold TOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | 0 none, 1 push, 2 pop, 3 write slot, 4 initialise |
| cmd_slot | input | 3 | Stack-relative slot for write |
| wdata | input | 80 | Data for push or write |
| rd_en | input | 1 | Read strobe, checked for underflow |
| rd_slot | input | 3 | Stack-relative slot for read |
| rd_data | output | 80 | Combinational data of rd_slot |
| cc_we | input | 1 | Load condition codes |
| cc_in | input | 4 | {C3,C2,C1,C0} |
| ext_flags | input | 6 | Exception flags from the arithmetic side |
| exc_mask | input | 6 | Control-word mask, 1 = masked |
| busy_in | input | 1 | Busy indication for status bit 15 |
| status_word | output | 16 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can act on C1 in the same cycle: a condition-code load from the arithmetic side, and a stack fault. The bench provokes this by asserting cc_we with all four codes at one, together with a pop of an empty stack. It then checks that C3, C2 and C0 come from cc_in while C1 reads 0, the underflow direction. The bench also makes an overflow happen on a full stack and checks that the top slot still returns the last pushed data.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int STK_DEPTH = 8;
  localparam int PTR_W     = $clog2(STK_DEPTH);
  localparam int CC_W      = 4;
  localparam int STAT_W    = 16;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_WRITE = 3'd3,
    OP_INIT  = 3'd4
  } stk_op_e;

  // stack-relative slot to physical entry
  function automatic logic [PTR_W-1:0] slot_to_phys(
      input logic [PTR_W-1:0] top, input logic [PTR_W-1:0] slot);
    return top + slot;
  endfunction

  // entry a push would fill
  function automatic logic [PTR_W-1:0] push_target(input logic [PTR_W-1:0] top);
    return top - PTR_W'(1);
  endfunction

  // cc is {C3,C2,C1,C0}
  function automatic logic [STAT_W-1:0] pack_status(
      input logic [5:0] flags, input logic fault, input logic [CC_W-1:0] cc,
      input logic [PTR_W-1:0] top, input logic busy);
    logic [STAT_W-1:0] s;
    s        = '0;
    s[5:0]   = flags;
    s[6]     = fault;
    s[7]     = |flags;
    s[8]     = cc[0];
    s[9]     = cc[1];
    s[10]    = cc[2];
    s[13:11] = top;
    s[14]    = cc[3];
    s[15]    = busy;
    return s;
  endfunction
endpackage

// File: rtl/fps_entries.sv
module fps_entries
  import fps_pkg::*;
#(
  parameter int DATA_W = 80
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [PTR_W-1:0]     wr_idx,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 clr_en,
  input  logic [PTR_W-1:0]     clr_idx,
  input  logic                 clr_all,
  input  logic [PTR_W-1:0]     rd_idx,
  output logic [DATA_W-1:0]    rd_data,
  output logic [STK_DEPTH-1:0] tags
);
  logic [DATA_W-1:0]    mem_q [STK_DEPTH];
  logic [STK_DEPTH-1:0] tag_q;
  logic [STK_DEPTH-1:0] we_vec;
  logic [STK_DEPTH-1:0] ce_vec;

  for (genvar g = 0; g < STK_DEPTH; g++) begin : g_dec
    localparam logic [PTR_W-1:0] MY_IDX = PTR_W'(g);
    assign we_vec[g] = wr_en  && (wr_idx  == MY_IDX);
    assign ce_vec[g] = clr_en && (clr_idx == MY_IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      for (int i = 0; i < STK_DEPTH; i++) mem_q[i] <= '0;
    end else if (clr_all) begin
      tag_q <= '0;
    end else begin
      for (int i = 0; i < STK_DEPTH; i++) begin
        if (we_vec[i]) begin
          mem_q[i] <= wr_data;
          tag_q[i] <= 1'b1;
        end else if (ce_vec[i]) begin
          tag_q[i] <= 1'b0;
        end
      end
    end
  end

  assign rd_data = mem_q[rd_idx];
  assign tags    = tag_q;
endmodule

// File: rtl/fps_ptr_ctl.sv
module fps_ptr_ctl
  import fps_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  stk_op_e              op,
  input  logic [PTR_W-1:0]     cmd_slot,
  input  logic                 rd_en,
  input  logic [PTR_W-1:0]     rd_slot,
  input  logic [STK_DEPTH-1:0] tags,
  output logic [PTR_W-1:0]     top,
  output logic [PTR_W-1:0]     rd_idx,
  output logic                 wr_en,
  output logic [PTR_W-1:0]     wr_idx,
  output logic                 clr_en,
  output logic [PTR_W-1:0]     clr_idx,
  output logic                 clr_all,
  output logic                 ev_push_ok,
  output logic                 ev_pop_ok,
  output logic                 ev_write,
  output logic                 ev_ovf,
  output logic                 ev_unf,
  output logic                 ev_init
);
  logic [PTR_W-1:0] top_q;
  logic [PTR_W-1:0] tgt_idx;
  logic [PTR_W-1:0] wslot_idx;
  logic             any_fault;
  logic             pop_empty;
  logic             rd_empty;

  assign top       = top_q;
  assign tgt_idx   = push_target(top_q);
  assign wslot_idx = slot_to_phys(top_q, cmd_slot);
  assign rd_idx    = slot_to_phys(top_q, rd_slot);

  assign ev_init   = (op == OP_INIT);
  assign pop_empty = (op == OP_POP) && !tags[top_q];
  assign rd_empty  = rd_en && !tags[rd_idx] && !ev_init;
  assign ev_ovf    = (op == OP_PUSH) && tags[tgt_idx];
  assign ev_unf    = pop_empty || rd_empty;
  assign any_fault = ev_ovf || ev_unf;

  assign ev_push_ok = (op == OP_PUSH)  && !any_fault;
  assign ev_pop_ok  = (op == OP_POP)   && !any_fault;
  assign ev_write   = (op == OP_WRITE) && !any_fault;

  assign wr_en   = ev_push_ok || ev_write;
  assign wr_idx  = ev_push_ok ? tgt_idx : wslot_idx;
  assign clr_en  = ev_pop_ok;
  assign clr_idx = top_q;
  assign clr_all = ev_init;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          top_q <= '0;
    else if (ev_init)    top_q <= '0;
    else if (ev_push_ok) top_q <= tgt_idx;
    else if (ev_pop_ok)  top_q <= top_q + PTR_W'(1);
  end
endmodule

// File: rtl/fps_status.sv
module fps_status
  import fps_pkg::*;
#(
  parameter int N_EXC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_ovf,
  input  logic              ev_unf,
  input  logic              ev_init,
  input  logic [N_EXC-1:0]  ext_flags,
  input  logic [N_EXC-1:0]  exc_mask,
  input  logic              cc_we,
  input  logic [CC_W-1:0]   cc_in,
  input  logic [PTR_W-1:0]  top,
  input  logic              busy_in,
  output logic [STAT_W-1:0] status_word,
  output logic              irq
);
  logic [N_EXC-1:0] flags_q;
  logic             sf_q;
  logic [CC_W-1:0]  cc_q;
  logic             fault;
  logic [N_EXC-1:0] fault_vec;
  logic [CC_W-1:0]  cc_nxt;

  assign fault     = ev_ovf || ev_unf;
  assign fault_vec = {{(N_EXC-1){1'b0}}, fault};

  always_comb begin
    cc_nxt = cc_we ? cc_in : cc_q;
    if (fault) cc_nxt[1] = ev_ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      sf_q    <= 1'b0;
      cc_q    <= '0;
    end else if (ev_init) begin
      flags_q <= '0;
      sf_q    <= 1'b0;
      cc_q    <= '0;
    end else begin
      flags_q <= flags_q | ext_flags | fault_vec;
      sf_q    <= sf_q | fault;
      cc_q    <= cc_nxt;
    end
  end

  assign status_word = pack_status(flags_q, sf_q, cc_q, top, busy_in);
  assign irq         = |(flags_q & ~exc_mask);
endmodule

// File: rtl/fpstack_regfile.sv
module fpstack_regfile
  import fps_pkg::*;
#(
  parameter int DATA_W = 80,
  parameter int N_EXC  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_op,
  input  logic [2:0]        cmd_slot,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [2:0]        rd_slot,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cc_we,
  input  logic [3:0]        cc_in,
  input  logic [N_EXC-1:0]  ext_flags,
  input  logic [N_EXC-1:0]  exc_mask,
  input  logic              busy_in,
  output logic [15:0]       status_word,
  output logic              irq
);
  logic [PTR_W-1:0]     top;
  logic [PTR_W-1:0]     rd_idx;
  logic                 wr_en;
  logic [PTR_W-1:0]     wr_idx;
  logic                 clr_en;
  logic [PTR_W-1:0]     clr_idx;
  logic                 clr_all;
  logic [STK_DEPTH-1:0] tags;
  logic                 ev_push_ok;
  logic                 ev_pop_ok;
  logic                 ev_write;
  logic                 ev_ovf;
  logic                 ev_unf;
  logic                 ev_init;

  fps_ptr_ctl u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (stk_op_e'(cmd_op)),
    .cmd_slot   (cmd_slot),
    .rd_en      (rd_en),
    .rd_slot    (rd_slot),
    .tags       (tags),
    .top        (top),
    .rd_idx     (rd_idx),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .clr_en     (clr_en),
    .clr_idx    (clr_idx),
    .clr_all    (clr_all),
    .ev_push_ok (ev_push_ok),
    .ev_pop_ok  (ev_pop_ok),
    .ev_write   (ev_write),
    .ev_ovf     (ev_ovf),
    .ev_unf     (ev_unf),
    .ev_init    (ev_init)
  );

  fps_entries #(.DATA_W(DATA_W)) u_ent (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wdata),
    .clr_en  (clr_en),
    .clr_idx (clr_idx),
    .clr_all (clr_all),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .tags    (tags)
  );

  fps_status #(.N_EXC(N_EXC)) u_st (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_ovf      (ev_ovf),
    .ev_unf      (ev_unf),
    .ev_init     (ev_init),
    .ext_flags   (ext_flags),
    .exc_mask    (exc_mask),
    .cc_we       (cc_we),
    .cc_in       (cc_in),
    .top         (top),
    .busy_in     (busy_in),
    .status_word (status_word),
    .irq         (irq)
  );
endmodule

// File: rtl/fps_checker.sv
module fps_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] status_word,
  input logic        ev_push_ok,
  input logic        ev_pop_ok,
  input logic        ev_ovf,
  input logic        ev_unf,
  input logic        ev_init
);
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_init |=> (status_word[14:0] == 15'd0)); // R1
  AST_PUSH_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push_ok |=> (status_word[13:11] == $past(status_word[13:11]) - 3'd1)); // R3
  AST_POP_INCREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop_ok |=> (status_word[13:11] == $past(status_word[13:11]) + 3'd1)); // R4
  AST_FAULT_FREEZES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ovf || ev_unf) |=> $stable(status_word[13:11])); // R5
  AST_FAULT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ovf || ev_unf) |=> (status_word[0] && status_word[6])); // R6
  AST_OVERFLOW_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> status_word[9]); // R5
  AST_UNDERFLOW_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_unf && !ev_ovf) |=> !status_word[9]); // R6
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_word[5:0] != 6'd0) && !ev_init)
      |=> ((status_word[5:0] & $past(status_word[5:0])) == $past(status_word[5:0]))); // R8
endmodule

bind fpstack_regfile fps_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .status_word (status_word),
  .ev_push_ok  (ev_push_ok),
  .ev_pop_ok   (ev_pop_ok),
  .ev_ovf      (ev_ovf),
  .ev_unf      (ev_unf),
  .ev_init     (ev_init)
);

// File: tb/sim_fpstack_regfile.sv
`timescale 1ns/1ps
module sim_fpstack_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [2:0]  cmd_slot = 3'd0;
  logic [79:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_slot = 3'd0;
  logic [79:0] rd_data;
  logic        cc_we = 1'b0;
  logic [3:0]  cc_in = 4'd0;
  logic [5:0]  ext_flags = 6'd0;
  logic [5:0]  exc_mask = 6'h3F;
  logic        busy_in = 1'b0;
  logic [15:0] status_word;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;   // 0 status, 1 rd_data, 2 irq
    logic [79:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  fpstack_regfile u0 (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_slot(cmd_slot), .wdata(wdata),
    .rd_en(rd_en), .rd_slot(rd_slot), .rd_data(rd_data), .cc_we(cc_we), .cc_in(cc_in),
    .ext_flags(ext_flags), .exc_mask(exc_mask), .busy_in(busy_in),
    .status_word(status_word), .irq(irq)
  );

  // status layout as stated in R1, R5, R6, R8, R10, R11, R12
  function automatic logic [15:0] st(input logic [5:0] fl, input logic sf,
      input logic [3:0] cc, input logic [2:0] tp, input logic bz);
    logic [15:0] s;
    s = 16'd0;
    s[5:0] = fl; s[6] = sf; s[7] = |fl;
    s[8] = cc[0]; s[9] = cc[1]; s[10] = cc[2]; s[14] = cc[3];
    s[13:11] = tp; s[15] = bz;
    return s;
  endfunction

  task automatic expect_item(input int kind, input logic [79:0] v, input string req);
    item_t it;
    it.kind = kind; it.exp = v; it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: compares all queued expectations at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [79:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0: act = {64'd0, status_word};
        1: act = rd_data;
        default: act = {79'd0, irq};
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #2;
    cmd_op = 3'd0; rd_en = 1'b0; cc_we = 1'b0; ext_flags = 6'd0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    expect_item(0, 80'(st(6'd0, 0, 4'd0, 3'd0, 0)), "R1 reset status");
    expect_item(2, 80'd0, "R1 reset irq");
    tick();

    // read strobe on empty stack
    rd_en = 1'b1; rd_slot = 3'd0; tick();
    expect_item(0, 80'(st(6'd1, 1, 4'd0, 3'd0, 0)), "R6 read of empty slot");
    cmd_op = 3'd4; tick();
    expect_item(0, 80'(st(6'd0, 0, 4'd0, 3'd0, 0)), "R1 initialise clears");

    cmd_op = 3'd1; wdata = 80'hA; tick();
    expect_item(0, 80'(st(6'd0, 0, 4'd0, 3'd7, 0)), "R3 R12 push wraps TOP to 7");
    rd_slot = 3'd0; expect_item(1, 80'hA, "R3 pushed data at slot 0");
    cmd_op = 3'd1; wdata = 80'hB; tick();
    expect_item(0, 80'(st(6'd0, 0, 4'd0, 3'd6, 0)), "R3 R12 second push TOP 6");
    rd_slot = 3'd1; expect_item(1, 80'hA, "R2 old top at slot 1");
    tick();
    rd_slot = 3'd0; expect_item(1, 80'hB, "R2 new top at slot 0");
    cmd_op = 3'd2; tick();
    expect_item(0, 80'(st(6'd0, 0, 4'd0, 3'd7, 0)), "R4 pop TOP back to 7");
    rd_slot = 3'd0; expect_item(1, 80'hA, "R4 slot 0 after pop");
    cmd_op = 3'd3; cmd_slot = 3'd1; wdata = 80'hC; tick();
    expect_item(0, 80'(st(6'd0, 0, 4'd0, 3'd7, 0)), "R7 write keeps TOP");
    rd_slot = 3'd1; expect_item(1, 80'hC, "R7 written slot data");

    for (int k = 0; k < 6; k++) begin
      cmd_op = 3'd1; wdata = 80'(100 + k); tick();
    end
    expect_item(0, 80'(st(6'd0, 0, 4'd0, 3'd1, 0)), "R3 full stack TOP 1");
    cmd_op = 3'd1; wdata = 80'hEEEE; tick();
    expect_item(0, 80'(st(6'd1, 1, 4'b0010, 3'd1, 0)), "R5 overflow flags and C1");
    rd_slot = 3'd0; expect_item(1, 80'd105, "R5 overflow leaves data");

    cmd_op = 3'd4; tick();
    cc_we = 1'b1; cc_in = 4'b1011; tick();
    expect_item(0, 80'(st(6'd0, 0, 4'b1011, 3'd0, 0)), "R10 condition code load");
    cc_we = 1'b1; cc_in = 4'b1111; cmd_op = 3'd2; tick();
    expect_item(0, 80'(st(6'd1, 1, 4'b1101, 3'd0, 0)), "R10 R6 fault overrides C1");

    cmd_op = 3'd4; tick();
    exc_mask = 6'h3F; ext_flags = 6'b001000; tick();
    expect_item(0, 80'(st(6'b001000, 0, 4'd0, 3'd0, 0)), "R8 external flag and summary");
    expect_item(2, 80'd0, "R9 masked flag no irq");
    tick();
    expect_item(0, 80'(st(6'b001000, 0, 4'd0, 3'd0, 0)), "R8 flag is sticky");
    exc_mask = 6'h37; expect_item(2, 80'd1, "R9 unmasked flag raises irq");
    tick();
    busy_in = 1'b1;
    expect_item(0, 80'(st(6'b001000, 0, 4'd0, 3'd0, 1)), "R11 busy bit");
    tick();
    busy_in = 1'b0;
    tick();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule